// File: doc/BRIEF.md
# UART Register Front End with Receive Queue and Interrupt

This block is the software-visible side of a simple UART. A 32-bit register bus reaches a control register, a read-only status register, interrupt enable and interrupt flag registers, and a set of plain storage registers for the clock divider, oversampling, pin, DMA and wake settings. Received bytes arrive on a byte-wide push interface and wait in an 8-entry receive queue. Software reads the queue through a data port that pops entries and a peek port that does not. Each byte written to the data port leaves the block as a one-cycle transmit strobe. Serialisation and baud generation sit outside the block.

Two interrupt sources exist. The receive-threshold flag rises when a push leaves the queue at or above a programmable level. The transmit half-empty flag rises on every data-port write. Flags are cleared by writing ones, and a single level interrupt line reports any flag that is also enabled.

Register word offsets (byte address): data 0x00, peek 0x04, control 0x08, status 0x0C, interrupt enable 0x10, interrupt flags 0x14, divider 0x18, oversampling 0x1C, pin 0x20, DMA 0x24, wake enable 0x28, wake flags 0x2C.

Top module: `uart_csr_top`

## Requirements
- R1: The receive queue holds 8 bytes. `rxFree` shows the number of empty entries while control bit 6 (clock enable) is set and 0 otherwise; a push is accepted only when `rxFree` is nonzero, otherwise the byte is dropped.
- R2: Control bits [3:0] give the receive threshold; an accepted push that leaves the occupancy at or above it sets interrupt flag bit 0.
- R3: `irq` is high exactly when the interrupt flag register ANDed with the interrupt enable register is nonzero.
- R4: Writing the interrupt flag register clears each flag bit written as 1 and keeps the others; a flag set by hardware in the same cycle stays set.
- R5: A control write with bit 4 set empties the receive queue, and a push in that same cycle is dropped; control bits 4 and 5 always read back as 0.
- R6: A control write with bit 6 set stores bit 7 as 1 as well.
- R7: Status reads give bit 0 = queue empty, bit 1 = 1 (transmit empty), bits [11:8] = queue occupancy; writes to status change nothing.
- R8: A data-port read returns and removes the oldest byte, or returns 0 when empty; a peek-port read returns the oldest byte (0 if empty) without removing it; a push and a pop in one cycle leave the occupancy unchanged.
- R9: A data-port write raises `txValid` for one cycle, starting the cycle after the write, with `txData` equal to the low 8 bits written, and sets interrupt flag bit 1.
- R10: After reset all registers read 0 except the pin register, which reads 0x1 (RTS bit 0 set), and the queue is empty.
- R11: Only accesses with all four byte enables set are decoded; reads of offsets 0x30 and above return 0 and writes there are ignored; the divider, oversampling, pin, DMA and wake registers read back the full word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address within the 1 KiB window |
| busByteEn | input | 4 | Byte enables; only 4'hF is decoded |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request; data returned in the same cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, 0 when no decoded read |
| rxValid | input | 1 | Received byte present |
| rxData | input | 8 | Received byte |
| rxFree | output | 4 | Free queue entries offered to the receiver |
| txValid | output | 1 | Transmit byte strobe |
| txData | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can share a clock edge: a byte push together with a software write that clears the receive-threshold flag, and a byte push together with a data-port read that pops. The bench drives both in the same cycle, with threshold 1 so the push must set the flag, and then judges that the flag and `irq` remain high, that the read returned the older byte, and that occupancy is unchanged with the new byte now at the head.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int ADDR_W = 10;
  localparam int NUM_REGS = 12;

  // control register bit positions
  localparam int THR_W      = 4;
  localparam int BIT_FLUSH_RX = 4;
  localparam int BIT_FLUSH_TX = 5;
  localparam int BIT_CLK_EN   = 6;
  localparam int BIT_CLK_RDY  = 7;

  // status register bit positions
  localparam int BIT_RX_EMPTY = 0;
  localparam int BIT_TX_EMPTY = 1;
  localparam int LVL_LSB      = 8;

  // interrupt flag bit positions
  localparam int FLG_RX_THR = 0;
  localparam int FLG_TX_HE  = 1;
  localparam int FLG_W      = 2;

  localparam logic [31:0] PIN_RESET = 32'h0000_0001;

  // word index of each register equals the enum value
  typedef enum logic [3:0] {
    SEL_DATA = 4'd0,
    SEL_PEEK = 4'd1,
    SEL_CTRL = 4'd2,
    SEL_STAT = 4'd3,
    SEL_IEN  = 4'd4,
    SEL_IFL  = 4'd5,
    SEL_DIV  = 4'd6,
    SEL_OVS  = 4'd7,
    SEL_PIN  = 4'd8,
    SEL_DMA  = 4'd9,
    SEL_WKEN = 4'd10,
    SEL_WKFL = 4'd11,
    SEL_NONE = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
  } busStrobe_t;

endpackage

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
  import uart_csr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] busAddr,
  input  logic [3:0]    busByteEn,
  input  logic          busWrEn,
  input  logic          busRdEn,
  output busStrobe_t    stb
);

  logic [AW-3:0] wordIdx;
  logic          fullWord;
  regSel_e       selDec;

  assign wordIdx  = busAddr[AW-1:2];
  assign fullWord = (busByteEn == 4'hF);

  always_comb begin
    if (32'(wordIdx) < NUM_REGS) selDec = regSel_e'(wordIdx[3:0]);
    else                         selDec = SEL_NONE;
  end

  always_comb begin
    stb.sel  = selDec;
    stb.wrEn = busWrEn && fullWord && (selDec != SEL_NONE);
    stb.rdEn = busRdEn && fullWord && (selDec != SEL_NONE);
  end

endmodule

// File: rtl/uart_csr_dp.sv
module uart_csr_dp
  import uart_csr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       stb,
  input  logic [31:0]      busWdata,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output logic [CNT_W-1:0] rxFree,
  output logic [31:0]      busRdata,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             irq
);

  logic [31:0] ctrlReg, ienReg, divReg, ovsReg, pinReg, dmaReg, wkenReg, wkflReg;
  logic [FLG_W-1:0] flagReg, flagClr, flagSet;
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] level, levelNext;
  logic flushNow, popNow, pushNow, thrHit, txNow;
  logic [7:0] head;

  function automatic logic wrHit(busStrobe_t s, regSel_e r);
    return s.wrEn && (s.sel == r);
  endfunction

  function automatic logic [PTR_W-1:0] ptrInc(logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign flushNow = wrHit(stb, SEL_CTRL) && busWdata[BIT_FLUSH_RX];
  assign popNow   = stb.rdEn && (stb.sel == SEL_DATA) && (level != '0);
  assign pushNow  = rxValid && ctrlReg[BIT_CLK_EN] && (32'(level) < DEPTH) && !flushNow;
  assign txNow    = wrHit(stb, SEL_DATA);

  assign levelNext = level + CNT_W'(pushNow) - CNT_W'(popNow);
  assign thrHit    = pushNow && (32'(levelNext) >= 32'(ctrlReg[THR_W-1:0]));

  assign rxFree = ctrlReg[BIT_CLK_EN] ? CNT_W'(DEPTH) - level : '0;
  assign head   = (level != '0) ? mem[rdPtr] : 8'h00;
  assign irq    = |({{(32-FLG_W){1'b0}}, flagReg} & ienReg);

  // clear from software, set from hardware; set wins
  assign flagClr = wrHit(stb, SEL_IFL) ? busWdata[FLG_W-1:0] : '0;
  always_comb begin
    flagSet = '0;
    flagSet[FLG_RX_THR] = thrHit;
    flagSet[FLG_TX_HE]  = txNow;
  end

  always_ff @(posedge clk) begin
    if (pushNow) mem[wrPtr] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (flushNow) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (pushNow) wrPtr <= ptrInc(wrPtr);
      if (popNow)  rdPtr <= ptrInc(rdPtr);
      level <= levelNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ienReg  <= '0;
      divReg  <= '0;
      ovsReg  <= '0;
      pinReg  <= PIN_RESET;
      dmaReg  <= '0;
      wkenReg <= '0;
      wkflReg <= '0;
      flagReg <= '0;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      flagReg <= (flagReg & ~flagClr) | flagSet;
      txValid <= txNow;
      if (txNow) txData <= busWdata[7:0];
      if (wrHit(stb, SEL_CTRL)) begin
        ctrlReg <= busWdata;
        ctrlReg[BIT_FLUSH_RX] <= 1'b0;
        ctrlReg[BIT_FLUSH_TX] <= 1'b0;
        if (busWdata[BIT_CLK_EN]) ctrlReg[BIT_CLK_RDY] <= 1'b1;
      end
      if (wrHit(stb, SEL_IEN))  ienReg  <= busWdata;
      if (wrHit(stb, SEL_DIV))  divReg  <= busWdata;
      if (wrHit(stb, SEL_OVS))  ovsReg  <= busWdata;
      if (wrHit(stb, SEL_PIN))  pinReg  <= busWdata;
      if (wrHit(stb, SEL_DMA))  dmaReg  <= busWdata;
      if (wrHit(stb, SEL_WKEN)) wkenReg <= busWdata;
      if (wrHit(stb, SEL_WKFL)) wkflReg <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdEn) begin
      unique case (stb.sel)
        SEL_DATA: busRdata = {24'h0, head};
        SEL_PEEK: busRdata = {24'h0, head};
        SEL_CTRL: busRdata = ctrlReg;
        SEL_STAT: begin
          busRdata[BIT_RX_EMPTY] = (level == '0);
          busRdata[BIT_TX_EMPTY] = 1'b1;
          busRdata[LVL_LSB +: CNT_W] = level;
        end
        SEL_IEN:  busRdata = ienReg;
        SEL_IFL:  busRdata = {{(32-FLG_W){1'b0}}, flagReg};
        SEL_DIV:  busRdata = divReg;
        SEL_OVS:  busRdata = ovsReg;
        SEL_PIN:  busRdata = pinReg;
        SEL_DMA:  busRdata = dmaReg;
        SEL_WKEN: busRdata = wkenReg;
        SEL_WKFL: busRdata = wkflReg;
        default:  busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic [3:0]       busByteEn,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output logic [CNT_W-1:0] rxFree,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             irq
);

  busStrobe_t stb;

  uart_csr_ctrl #(.AW(AW)) u_ctrl (
    .busAddr  (busAddr),
    .busByteEn(busByteEn),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .stb      (stb)
  );

  uart_csr_dp #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busWdata(busWdata),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxFree  (rxFree),
    .busRdata(busRdata),
    .txValid (txValid),
    .txData  (txData),
    .irq     (irq)
  );

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
  import uart_csr_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    busAddr,
  input logic [3:0]       busByteEn,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [31:0]      busWdata,
  input logic [31:0]      busRdata,
  input logic             rxValid,
  input logic [CNT_W-1:0] rxFree,
  input logic             txValid,
  input logic [7:0]       txData,
  input logic             irq
);

  logic fullAcc;
  logic [AW-3:0] idx;
  assign fullAcc = (busByteEn == 4'hF);
  assign idx     = busAddr[AW-1:2];

  a_r4_clear_all_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && fullAcc && 32'(idx) == 5 && busWdata[FLG_W-1:0] == '1 && !rxValid) |=> !irq);

  a_r9_tx_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && fullAcc && idx == '0) |=> (txValid && txData == $past(busWdata[7:0])));

  a_r9_tx_single: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && fullAcc && idx == '0) |=> !txValid);

  a_r1_clock_off_no_room: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && fullAcc && 32'(idx) == 2 && !busWdata[BIT_CLK_EN]) |=> (rxFree == '0));

  a_r5_flush_frees_all: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && fullAcc && 32'(idx) == 2 && busWdata[BIT_FLUSH_RX] && busWdata[BIT_CLK_EN])
      |=> (32'(rxFree) == DEPTH));

  a_r7_tx_empty_bit: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && fullAcc && 32'(idx) == 3) |-> busRdata[BIT_TX_EMPTY]);

  a_r11_partial_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !fullAcc) |-> (busRdata == '0));

endmodule

bind uart_csr_top uart_csr_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busByteEn(busByteEn),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .rxValid  (rxValid),
  .rxFree   (rxFree),
  .txValid  (txValid),
  .txData   (txData),
  .irq      (irq)
);

// File: tb/uart_csr_top_tb.sv
module uart_csr_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  localparam logic [9:0] A_DATA = 10'h000, A_PEEK = 10'h004, A_CTRL = 10'h008,
    A_STAT = 10'h00C, A_IEN = 10'h010, A_IFL = 10'h014, A_DIV = 10'h018,
    A_OVS = 10'h01C, A_PIN = 10'h020, A_DMA = 10'h024, A_WKEN = 10'h028,
    A_WKFL = 10'h02C, A_BAD = 10'h030;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic [3:0]  rxFree;
  logic        txValid;
  logic [7:0]  txData;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_csr_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxFree(rxFree),
    .txValid(txValid), .txData(txData), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic [9:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    busAddr = a; busWdata = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic busRd(logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rdCheck(string tag, logic [9:0] a, logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(tag, v, exp);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  function automatic logic [31:0] statOf(int n);
    return (32'(n) << 8) | 32'h2 | ((n == 0) ? 32'h1 : 32'h0);
  endfunction

  task automatic clean(logic [31:0] ctrl);
    busWr(A_CTRL, ctrl | 32'h10);
    busWr(A_IFL, 32'hFFFF_FFFF);
    busWr(A_IEN, 32'h0);
  endtask

  task automatic t_reset;
    check("R10 irq after reset", {31'b0, irq}, 0);
    check("R10 rxFree after reset", {28'b0, rxFree}, 0);
    check("R10 txValid after reset", {31'b0, txValid}, 0);
    rdCheck("R10 ctrl reset", A_CTRL, 0);
    rdCheck("R10 ien reset", A_IEN, 0);
    rdCheck("R10 ifl reset", A_IFL, 0);
    rdCheck("R10 div reset", A_DIV, 0);
    rdCheck("R10 pin reset", A_PIN, 32'h1);
    rdCheck("R10 R7 status reset", A_STAT, statOf(0));
  endtask

  task automatic t_storage;
    busWr(A_DIV, 32'hDEAD_0001);
    busWr(A_OVS, 32'h0000_0005);
    busWr(A_PIN, 32'h8000_0002);
    busWr(A_DMA, 32'h1234_5678);
    busWr(A_WKEN, 32'hA5A5_A5A5);
    busWr(A_WKFL, 32'h0F0F_0F0F);
    rdCheck("R11 div readback", A_DIV, 32'hDEAD_0001);
    rdCheck("R11 ovs readback", A_OVS, 32'h5);
    rdCheck("R11 pin readback", A_PIN, 32'h8000_0002);
    rdCheck("R11 dma readback", A_DMA, 32'h1234_5678);
    rdCheck("R11 wake en readback", A_WKEN, 32'hA5A5_A5A5);
    rdCheck("R11 wake flag readback", A_WKFL, 32'h0F0F_0F0F);
    busWr(A_DIV, 32'h0000_00FF, 4'h1);
    rdCheck("R11 partial write ignored", A_DIV, 32'hDEAD_0001);
    busWr(A_BAD, 32'hFFFF_FFFF);
    rdCheck("R11 unmapped read zero", A_BAD, 0);
    rdCheck("R11 unmapped write no effect", A_DIV, 32'hDEAD_0001);
    busWr(A_STAT, 32'hFFFF_FFFF);
    rdCheck("R7 status write ignored", A_STAT, statOf(0));
  endtask

  task automatic t_ctrl;
    busWr(A_CTRL, 32'h0000_007F);
    rdCheck("R5 R6 ctrl flush bits dropped, ready set", A_CTRL, 32'h0000_00CF);
    check("R1 rxFree with clock on", {28'b0, rxFree}, 8);
    busWr(A_CTRL, 32'h0000_0000);
    check("R1 rxFree with clock off", {28'b0, rxFree}, 0);
    push(8'h99);
    rdCheck("R1 push dropped with clock off", A_STAT, statOf(0));
  endtask

  task automatic t_fifo;
    clean(32'h43);
    busWr(A_IEN, 32'h1);
    push(8'hA1);
    push(8'hB2);
    check("R2 below threshold no irq", {31'b0, irq}, 0);
    rdCheck("R7 status level 2", A_STAT, statOf(2));
    push(8'hC3);
    check("R2 R3 threshold reached irq", {31'b0, irq}, 1);
    rdCheck("R2 flag bit0", A_IFL, 32'h1);
    rdCheck("R8 peek head", A_PEEK, 32'hA1);
    rdCheck("R8 peek does not pop", A_STAT, statOf(3));
    rdCheck("R8 pop first", A_DATA, 32'hA1);
    rdCheck("R8 pop second", A_DATA, 32'hB2);
    rdCheck("R8 pop third", A_DATA, 32'hC3);
    rdCheck("R8 pop empty zero", A_DATA, 0);
    rdCheck("R8 peek empty zero", A_PEEK, 0);
    rdCheck("R7 status empty", A_STAT, statOf(0));
  endtask

  task automatic t_full;
    clean(32'h48);
    busWr(A_IEN, 32'h1);
    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    check("R2 seven below threshold 8", {31'b0, irq}, 0);
    push(8'h17);
    check("R2 eight reaches threshold", {31'b0, irq}, 1);
    check("R1 rxFree full", {28'b0, rxFree}, 0);
    push(8'hEE);
    rdCheck("R1 push when full dropped", A_STAT, statOf(8));
    rdCheck("R8 pop oldest after fill", A_DATA, 32'h10);
    check("R1 rxFree after pop", {28'b0, rxFree}, 1);
    busWr(A_CTRL, 32'h50);
    rdCheck("R5 flush empties", A_STAT, statOf(0));
    check("R5 rxFree after flush", {28'b0, rxFree}, 8);
    rdCheck("R5 R6 ctrl after flush", A_CTRL, 32'hC0);
  endtask

  task automatic t_flush_push;
    clean(32'h41);
    push(8'h01);
    @(negedge clk);
    busAddr = A_CTRL; busWdata = 32'h51; busWrEn = 1'b1;
    rxValid = 1'b1; rxData = 8'h02;
    @(negedge clk);
    busWrEn = 1'b0; rxValid = 1'b0;
    rdCheck("R5 push during flush dropped", A_STAT, statOf(0));
  endtask

  task automatic t_tx_w1c;
    clean(32'h41);
    busWr(A_DATA, 32'h1234_56A5);
    check("R9 txValid after write", {31'b0, txValid}, 1);
    check("R9 txData low byte", {24'b0, txData}, 32'hA5);
    @(negedge clk);
    check("R9 txValid one cycle", {31'b0, txValid}, 0);
    rdCheck("R9 half-empty flag", A_IFL, 32'h2);
    check("R3 irq masked", {31'b0, irq}, 0);
    busWr(A_IEN, 32'h2);
    check("R3 irq enabled", {31'b0, irq}, 1);
    push(8'h33);
    rdCheck("R2 both flags", A_IFL, 32'h3);
    busWr(A_IFL, 32'h2);
    rdCheck("R4 clear only bit1", A_IFL, 32'h1);
    check("R3 irq off after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_concurrent;
    clean(32'h41);
    busWr(A_IEN, 32'h1);
    @(negedge clk);
    busAddr = A_IFL; busWdata = 32'h1; busWrEn = 1'b1;
    rxValid = 1'b1; rxData = 8'h5A;
    @(negedge clk);
    busWrEn = 1'b0; rxValid = 1'b0;
    check("R4 set wins over clear irq", {31'b0, irq}, 1);
    rdCheck("R4 set wins over clear flag", A_IFL, 32'h1);
    begin
      logic [31:0] v;
      @(negedge clk);
      busAddr = A_DATA; busRdEn = 1'b1;
      rxValid = 1'b1; rxData = 8'h6B;
      #1 v = busRdata;
      @(negedge clk);
      busRdEn = 1'b0; rxValid = 1'b0;
      check("R8 pop during push returns older", v, 32'h5A);
    end
    rdCheck("R8 level kept on push and pop", A_STAT, statOf(1));
    rdCheck("R8 new head after push and pop", A_PEEK, 32'h6B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_ctrl();
    t_fifo();
    t_full();
    t_flush_push();
    t_tx_w1c();
    t_concurrent();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule